// File: doc/BRIEF.md
# BCD calendar clock with alarm

This block keeps wall-clock time as six packed-BCD fields (seconds, minutes, hours, day of month, month and two-digit year for 2000 to 2099) in 24-hour form. Time advances once for every `DIV_TICKS` pulses of a slow tick enable, nominally a 32.768 kHz strobe. Software sets the clock, the alarm, the run control and the interrupt enables through a byte-wide register port. Reads are combinational from the address.

A full-field alarm comparator raises a sticky alarm flag when the clock steps onto a time equal to all six alarm fields. Every step also sets a sticky one-second event flag. Both flags are cleared by writing 1. A BUSY status bit covers the last tick interval before each step, so software can hold off accesses that would straddle an update. Two level interrupt outputs carry the flags, each gated by its own enable bit.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset the time reads 00:00:00 on day 01, month 01, year 00. The control, status and interrupt-enable registers read 0x00, and both interrupt outputs are low.
- R2: The seconds field advances once per `DIV_TICKS` tick enables while control bit 0 (run) is 1. While run is 0, tick enables leave every time field unchanged.
- R3: Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours. Hours wrap from 23 to 00 and carry into the day. All fields are packed BCD at offsets 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 (seconds through year).
- R4: The day wraps to 01 after the last day of the month: 30 for months 04, 06, 09 and 11, 31 for the other months, and for month 02 either 29 (year divisible by 4) or 28. Month 12 wraps to 01 with a year carry, and year 99 wraps to 00.
- R5: A write to any time field loads it at once and restarts the sub-second divider. The next step comes after exactly `DIV_TICKS` further tick enables.
- R6: Status bit 0 (BUSY, offset 0x44) is 1 while running and in the final tick interval before a step, and 0 at all other times.
- R7: Status bit 2 is set by every step and stays set. Writing 1 to it clears it, and writing 0 leaves it set.
- R8: Status bit 6 is set when a step lands on a time equal to all six alarm fields (offsets 0x20 to 0x34). A mismatch in any single field, the year included, leaves it clear. Writing 1 clears it.
- R9: If a write-1-to-clear of a status flag falls in the same cycle as the event that sets that flag, the flag ends up set.
- R10: The interrupt enable register sits at 0x48. Its bit 3 gates `alarmIrq` (alarm flag AND enable) and its bit 2 gates `timerIrq` (second flag AND enable).
- R11: The control register at 0x40 reads back only bit 0. Bit 3 always reads 0, which fixes 24-hour mode, and writes to it are ignored. Status bit 1 mirrors the run bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle pulse per slow oscillator tick |
| addr | input | 8 | Register byte address |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr` |
| alarmIrq | output | 1 | Alarm interrupt, level |
| timerIrq | output | 1 | One-second interrupt, level |

## Verification
The one-second step and a software write-1-to-clear of the second flag can land on the same clock edge. In that case the clear must lose. The bench provokes this by counting tick enables from a time write, so it knows which tick is the last one. It then drives that tick enable and a status write of 0x04 in the same cycle. It judges the result by reading status bit 2 back as 1, and it confirms the new second value. A following clear with no step in its cycle must then return bit 2 to 0.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int FIELD_COUNT = 6;

  typedef logic [7:0] bcdByte_t;
  typedef bcdByte_t [FIELD_COUNT-1:0] calendar_t;

  // field indices (position within calendar_t and address bits [4:2])
  localparam logic [2:0] F_SEC  = 3'd0;
  localparam logic [2:0] F_MIN  = 3'd1;
  localparam logic [2:0] F_HOUR = 3'd2;
  localparam logic [2:0] F_DAY  = 3'd3;
  localparam logic [2:0] F_MON  = 3'd4;
  localparam logic [2:0] F_YEAR = 3'd5;

  localparam logic [2:0] BANK_TIME  = 3'b000;
  localparam logic [2:0] BANK_ALARM = 3'b001;

  localparam logic [7:0] ADDR_CTRL = 8'h40;
  localparam logic [7:0] ADDR_STAT = 8'h44;
  localparam logic [7:0] ADDR_IEN  = 8'h48;

  localparam int CTRL_RUN   = 0;
  localparam int STAT_BUSY  = 0;
  localparam int STAT_RUN   = 1;
  localparam int STAT_SEC   = 2;
  localparam int STAT_ALARM = 6;
  localparam int IEN_TIMER  = 2;
  localparam int IEN_ALARM  = 3;

  localparam calendar_t TIME_RESET = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  // control -> datapath strobes
  typedef struct packed {
    logic       secStep;
    logic       timeWr;
    logic       alarmWr;
    logic [2:0] fieldSel;
  } rtcStrobe_t;

  function automatic logic fieldAddr(input logic [7:0] a, input logic [2:0] bank);
    return (a[7:5] == bank) && (a[1:0] == 2'b00) && (a[4:2] < 3'd6);
  endfunction
endpackage

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  rtcStrobe_t strobes,
  input  logic [7:0] wrData,
  output calendar_t  timeRegs,
  output calendar_t  alarmRegs,
  output logic       alarmEqNext
);
  calendar_t timeR, alarmR, nextT;
  logic      wrapS, wrapM, wrapH, wrapD, wrapMo;
  logic      leapYear;
  bcdByte_t  lastDay;
  logic [1:0] yearMod4;
  logic [FIELD_COUNT-1:0] fieldEq;

  function automatic bcdByte_t bcdInc(input bcdByte_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic bcdByte_t stepField(input bcdByte_t v, input bcdByte_t last,
                                         input bcdByte_t first, input logic en);
    if (!en) return v;
    if (v == last) return first;
    return bcdInc(v);
  endfunction

  // year value mod 4 from BCD digits: (10*T + U) mod 4 == (2*T[0] + U) mod 4
  assign yearMod4 = {timeR[F_YEAR][4], 1'b0} + timeR[F_YEAR][1:0];
  assign leapYear = (yearMod4 == 2'b00);

  always_comb begin
    case (timeR[F_MON])
      8'h02:                      lastDay = leapYear ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: lastDay = 8'h30;
      default:                    lastDay = 8'h31;
    endcase
  end

  assign wrapS  = (timeR[F_SEC] == 8'h59);
  assign wrapM  = wrapS && (timeR[F_MIN] == 8'h59);
  assign wrapH  = wrapM && (timeR[F_HOUR] == 8'h23);
  assign wrapD  = wrapH && (timeR[F_DAY] == lastDay);
  assign wrapMo = wrapD && (timeR[F_MON] == 8'h12);

  always_comb begin
    nextT[F_SEC]  = stepField(timeR[F_SEC],  8'h59, 8'h00, 1'b1);
    nextT[F_MIN]  = stepField(timeR[F_MIN],  8'h59, 8'h00, wrapS);
    nextT[F_HOUR] = stepField(timeR[F_HOUR], 8'h23, 8'h00, wrapM);
    nextT[F_DAY]  = stepField(timeR[F_DAY],  lastDay, 8'h01, wrapH);
    nextT[F_MON]  = stepField(timeR[F_MON],  8'h12, 8'h01, wrapD);
    nextT[F_YEAR] = stepField(timeR[F_YEAR], 8'h99, 8'h00, wrapMo);
  end

  generate
    for (genvar i = 0; i < FIELD_COUNT; i++) begin : g_cmp
      assign fieldEq[i] = (nextT[i] == alarmR[i]);
    end
  endgenerate
  assign alarmEqNext = &fieldEq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timeR  <= TIME_RESET;
      alarmR <= '0;
    end else begin
      if (strobes.timeWr)       timeR[strobes.fieldSel] <= wrData;
      else if (strobes.secStep) timeR <= nextT;
      if (strobes.alarmWr)      alarmR[strobes.fieldSel] <= wrData;
    end
  end

  assign timeRegs  = timeR;
  assign alarmRegs = alarmR;
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int DIV_TICKS = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tickEn,
  input  logic [7:0] addr,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       alarmEqNext,
  output rtcStrobe_t strobes,
  output logic       runBit,
  output logic       busyNow,
  output logic       secFlag,
  output logic       alarmFlag,
  output logic       ieAlarm,
  output logic       ieTimer
);
  localparam int DIV_W = (DIV_TICKS > 1) ? $clog2(DIV_TICKS) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_TICKS - 1);

  logic [DIV_W-1:0] divCnt;
  logic timeWr, alarmWr, ctrlWr, statWr, ienWr;
  logic lastTick, secStep;

  assign timeWr  = wrEn && fieldAddr(addr, BANK_TIME);
  assign alarmWr = wrEn && fieldAddr(addr, BANK_ALARM);
  assign ctrlWr  = wrEn && (addr == ADDR_CTRL);
  assign statWr  = wrEn && (addr == ADDR_STAT);
  assign ienWr   = wrEn && (addr == ADDR_IEN);

  assign lastTick = (divCnt == DIV_LAST);
  assign busyNow  = runBit && lastTick;
  assign secStep  = runBit && tickEn && lastTick && !timeWr;

  always_ff @(posedge clk) begin
    if (!rst_n)                divCnt <= '0;
    else if (timeWr)           divCnt <= '0;
    else if (runBit && tickEn) divCnt <= lastTick ? '0 : divCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      runBit    <= 1'b0;
      ieAlarm   <= 1'b0;
      ieTimer   <= 1'b0;
      secFlag   <= 1'b0;
      alarmFlag <= 1'b0;
    end else begin
      if (ctrlWr) runBit <= wrData[CTRL_RUN];
      if (ienWr) begin
        ieAlarm <= wrData[IEN_ALARM];
        ieTimer <= wrData[IEN_TIMER];
      end
      // set has priority over a same-cycle write-1-to-clear
      secFlag   <= secStep || (secFlag && !(statWr && wrData[STAT_SEC]));
      alarmFlag <= (secStep && alarmEqNext) ||
                   (alarmFlag && !(statWr && wrData[STAT_ALARM]));
    end
  end

  assign strobes.secStep  = secStep;
  assign strobes.timeWr   = timeWr;
  assign strobes.alarmWr  = alarmWr;
  assign strobes.fieldSel = addr[4:2];
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_pkg::*;
#(
  parameter int DIV_TICKS = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tickEn,
  input  logic [7:0] addr,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       alarmIrq,
  output logic       timerIrq
);
  rtcStrobe_t strobes;
  calendar_t  timeRegs, alarmRegs;
  logic alarmEqNext, runBit, busyNow, secFlag, alarmFlag, ieAlarm, ieTimer;

  rtc_ctrl #(.DIV_TICKS(DIV_TICKS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .alarmEqNext(alarmEqNext), .strobes(strobes),
    .runBit(runBit), .busyNow(busyNow), .secFlag(secFlag),
    .alarmFlag(alarmFlag), .ieAlarm(ieAlarm), .ieTimer(ieTimer)
  );

  rtc_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .wrData(wrData),
    .timeRegs(timeRegs), .alarmRegs(alarmRegs), .alarmEqNext(alarmEqNext)
  );

  always_comb begin
    rdData = 8'h00;
    if (fieldAddr(addr, BANK_TIME))       rdData = timeRegs[addr[4:2]];
    else if (fieldAddr(addr, BANK_ALARM)) rdData = alarmRegs[addr[4:2]];
    else if (addr == ADDR_CTRL)           rdData[CTRL_RUN] = runBit;
    else if (addr == ADDR_STAT) begin
      rdData[STAT_BUSY]  = busyNow;
      rdData[STAT_RUN]   = runBit;
      rdData[STAT_SEC]   = secFlag;
      rdData[STAT_ALARM] = alarmFlag;
    end else if (addr == ADDR_IEN) begin
      rdData[IEN_ALARM] = ieAlarm;
      rdData[IEN_TIMER] = ieTimer;
    end
  end

  assign alarmIrq = alarmFlag && ieAlarm;
  assign timerIrq = secFlag && ieTimer;
endmodule

// File: rtl/rtc_bcd_checker.sv
module rtc_bcd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       secStep,
  input logic       timeWr,
  input logic       runBit,
  input logic       busyNow,
  input logic       secFlag,
  input logic       alarmFlag,
  input logic       alarmIrq,
  input logic       timerIrq,
  input logic [7:0] secReg
);
  a_r6_step_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    secStep |-> busyNow);

  a_r2_frozen_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!runBit && !timeWr) |=> $stable(secReg));

  a_r7_sec_flag_from_step: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(secFlag) |-> $past(secStep));

  a_r8_alarm_flag_from_step: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarmFlag) |-> $past(secStep));

  a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    secStep |=> secFlag);

  a_r10_alarm_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    alarmIrq |-> alarmFlag);

  a_r10_timer_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    timerIrq |-> secFlag);
endmodule

bind rtc_bcd_core rtc_bcd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .secStep(strobes.secStep), .timeWr(strobes.timeWr),
  .runBit(runBit), .busyNow(busyNow), .secFlag(secFlag), .alarmFlag(alarmFlag),
  .alarmIrq(alarmIrq), .timerIrq(timerIrq), .secReg(timeRegs[0])
);

// File: tb/tb_rtc_bcd_core.sv
`timescale 1ns/1ps
module tb_rtc_bcd_core;
  localparam int DIV = 8;

  logic clk = 1'b0, rst_n = 1'b0, tickEn = 1'b0, wrEn = 1'b0;
  logic [7:0] addr = 8'h00, wrData = 8'h00;
  logic [7:0] rdData;
  logic alarmIrq, timerIrq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rtc_bcd_core #(.DIV_TICKS(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .alarmIrq(alarmIrq), .timerIrq(timerIrq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdData;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1'b1;
      @(negedge clk); tickEn = 1'b0;
    end
  endtask

  task automatic setTime(input logic [7:0] y, mo, d, h, mi, s);
    wr(8'h14, y); wr(8'h10, mo); wr(8'h0C, d);
    wr(8'h08, h); wr(8'h04, mi); wr(8'h00, s);
  endtask

  task automatic setAlarm(input logic [7:0] y, mo, d, h, mi, s);
    wr(8'h34, y); wr(8'h30, mo); wr(8'h2C, d);
    wr(8'h28, h); wr(8'h24, mi); wr(8'h20, s);
  endtask

  task automatic chkTime(input string tag, input logic [7:0] y, mo, d, h, mi, s);
    logic [7:0] v;
    rd(8'h14, v); chk({tag, " year"}, v, y);
    rd(8'h10, v); chk({tag, " month"}, v, mo);
    rd(8'h0C, v); chk({tag, " day"}, v, d);
    rd(8'h08, v); chk({tag, " hour"}, v, h);
    rd(8'h04, v); chk({tag, " min"}, v, mi);
    rd(8'h00, v); chk({tag, " sec"}, v, s);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chkTime("R1 reset", 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
    rd(8'h40, v); chk("R1 ctrl", v, 8'h00);
    rd(8'h44, v); chk("R1 status", v, 8'h00);
    rd(8'h48, v); chk("R1 ien", v, 8'h00);
    chk("R1 irqs", {6'd0, alarmIrq, timerIrq}, 8'h00);
  endtask

  task automatic t_run_busy();
    logic [7:0] v;
    ticks(3);
    rd(8'h00, v); chk("R2 stopped sec", v, 8'h00);
    wr(8'h40, 8'h01);
    setTime(8'h21, 8'h06, 8'h15, 8'h10, 8'h20, 8'h30);
    ticks(DIV - 1);
    rd(8'h00, v); chk("R2 before step sec", v, 8'h30);
    rd(8'h44, v); chk("R6 busy before step", v, 8'h03);
    ticks(1);
    rd(8'h00, v); chk("R2 stepped sec", v, 8'h31);
    rd(8'h44, v); chk("R6 busy low and R7 event set", v, 8'h06);
    ticks(DIV);
    rd(8'h00, v); chk("R2 second step", v, 8'h32);
    wr(8'h40, 8'h00);
    ticks(2 * DIV);
    rd(8'h00, v); chk("R2 frozen after stop", v, 8'h32);
    rd(8'h44, v); chk("R6 no busy when stopped", v, 8'h04);
  endtask

  task automatic t_reload();
    logic [7:0] v;
    wr(8'h40, 8'h01);
    ticks(5);
    wr(8'h00, 8'h45);
    rd(8'h00, v); chk("R5 immediate load", v, 8'h45);
    ticks(DIV - 1);
    rd(8'h00, v); chk("R5 divider restarted", v, 8'h45);
    ticks(1);
    rd(8'h00, v); chk("R5 full second", v, 8'h46);
  endtask

  task automatic t_rollover();
    setTime(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h58);
    ticks(DIV);
    chkTime("R3 no carry yet", 8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
    setTime(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
    ticks(DIV);
    chkTime("R4 full wrap", 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
    setTime(8'h05, 8'h03, 8'h10, 8'h09, 8'h59, 8'h59);
    ticks(DIV);
    chkTime("R3 minute carry", 8'h05, 8'h03, 8'h10, 8'h10, 8'h00, 8'h00);
  endtask

  task automatic dayCase(input string tag, input logic [7:0] y, mo, d,
                         input logic [7:0] expMo, expD);
    logic [7:0] v;
    setTime(y, mo, d, 8'h23, 8'h59, 8'h59);
    ticks(DIV);
    rd(8'h0C, v); chk({tag, " day"}, v, expD);
    rd(8'h10, v); chk({tag, " month"}, v, expMo);
  endtask

  task automatic t_month_len();
    dayCase("R4 feb leap 28", 8'h24, 8'h02, 8'h28, 8'h02, 8'h29);
    dayCase("R4 feb leap 29", 8'h24, 8'h02, 8'h29, 8'h03, 8'h01);
    dayCase("R4 feb common", 8'h23, 8'h02, 8'h28, 8'h03, 8'h01);
    dayCase("R4 feb year 10", 8'h10, 8'h02, 8'h28, 8'h03, 8'h01);
    dayCase("R4 april end", 8'h22, 8'h04, 8'h30, 8'h05, 8'h01);
    dayCase("R4 nov end", 8'h22, 8'h11, 8'h30, 8'h12, 8'h01);
    dayCase("R4 jan 30", 8'h22, 8'h01, 8'h30, 8'h01, 8'h31);
  endtask

  task automatic t_w1c_race();
    logic [7:0] v;
    rd(8'h44, v); chk("R7 flag sticky", v[2], 1'b1);
    wr(8'h44, 8'h00);
    rd(8'h44, v); chk("R7 write 0 keeps", v[2], 1'b1);
    wr(8'h44, 8'h04);
    rd(8'h44, v); chk("R7 write 1 clears", v[2], 1'b0);
    setTime(8'h30, 8'h07, 8'h04, 8'h08, 8'h00, 8'h10);
    ticks(DIV);
    rd(8'h44, v); chk("R7 set again", v[2], 1'b1);
    ticks(DIV - 1);
    @(negedge clk); tickEn = 1'b1; addr = 8'h44; wrData = 8'h04; wrEn = 1'b1;
    @(negedge clk); tickEn = 1'b0; wrEn = 1'b0;
    rd(8'h44, v); chk("R9 set wins over clear", v[2], 1'b1);
    rd(8'h00, v); chk("R9 step happened", v, 8'h12);
    wr(8'h44, 8'h04);
    rd(8'h44, v); chk("R9 later clear works", v[2], 1'b0);
  endtask

  task automatic t_alarm();
    logic [7:0] v;
    wr(8'h48, 8'h08);
    setAlarm(8'h41, 8'h05, 8'h20, 8'h12, 8'h00, 8'h01);
    setTime(8'h40, 8'h05, 8'h20, 8'h12, 8'h00, 8'h00);
    ticks(DIV);
    rd(8'h44, v); chk("R8 year mismatch no flag", v[6], 1'b0);
    chk("R10 no alarm irq", {7'd0, alarmIrq}, 8'h00);
    wr(8'h34, 8'h40);
    setTime(8'h40, 8'h05, 8'h20, 8'h12, 8'h00, 8'h00);
    ticks(DIV);
    rd(8'h44, v); chk("R8 full match flag", v[6], 1'b1);
    chk("R10 alarm irq enabled", {7'd0, alarmIrq}, 8'h01);
    chk("R10 timer irq disabled", {7'd0, timerIrq}, 8'h00);
    ticks(DIV);
    rd(8'h44, v); chk("R8 flag sticky past match", v[6], 1'b1);
    wr(8'h48, 8'h04);
    chk("R10 alarm irq gated off", {7'd0, alarmIrq}, 8'h00);
    chk("R10 timer irq on", {7'd0, timerIrq}, 8'h01);
    rd(8'h48, v); chk("R10 ien readback", v, 8'h04);
    wr(8'h44, 8'h40);
    rd(8'h44, v); chk("R8 flag cleared", v[6], 1'b0);
  endtask

  task automatic t_ctrl();
    logic [7:0] v;
    wr(8'h40, 8'h09);
    rd(8'h40, v); chk("R11 ctrl 24h bit reads 0", v, 8'h01);
    rd(8'h44, v); chk("R11 status run bit", v[1], 1'b1);
    wr(8'h40, 8'h08);
    rd(8'h40, v); chk("R11 ctrl cleared", v, 8'h00);
    rd(8'h44, v); chk("R11 status run low", v[1], 1'b0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_run_busy();
    t_reload();
    t_rollover();
    t_month_len();
    t_w1c_race();
    t_alarm();
    t_ctrl();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule